// File: doc/BRIEF.md
# Register-Launched I2C Single-Byte Master

This block is an I2C bus master driven through a command word of four byte lanes. Software (or a small button harness) first fills the three upper lanes with the transfer direction, the 7-bit device address and the register index, in any order. Writing the lowest lane then both supplies the write data and launches one single-byte register access. The block drives START, the address phase, the register index phase and either a data write or a repeated START followed by a read phase, and it always finishes with STOP.

Both bus lines are open-drain: the block only ever pulls a line low or lets it float, and an external pull-up supplies the high level. When the access completes, the received byte, a busy flag and an acknowledge error flag are visible at the ports. Bursts, clock stretching and multi-master arbitration are not supported.

Top module: `i2c_cmd_master`

## Requirements
- R1: Writes to lanes 3, 2 and 1 (selected by `cmd_lane` = 3, 2, 1) are stored in any order and never start a transfer; the stored values are captured only when lane 0 is written.
- R2: A lane-0 write while idle starts a transfer: `busy` is high from the next clock edge until STOP completes, and then low again.
- R3: A lane-0 write while `busy` is high is ignored and has no effect on the running transfer or its data.
- R4: Lane 3 bit 7 selects the direction (1 = read, 0 = write); lane 2 bits 6:0 are the device address; lane 1 is the register index; lane 0 is the byte written by a write access.
- R5: A write access sends START, the address with R/W bit 0, the index, the data byte, then STOP; bytes go MSB first and each is followed by a ninth clock in which the slave acknowledges by holding SDA low.
- R6: A read access sends START, the address with R/W bit 0, the index, a repeated START, the address with R/W bit 1, clocks in 8 bits MSB first, answers with NACK (SDA released) and ends with STOP; `rd_byte` then holds the received byte.
- R7: `scl_lo` and `sda_lo` (1 = pull the line low) are both 0 while idle, and SDA is never moved in the same clock cycle as SCL, so data changes only while SCL is low and START/STOP occur only with SCL high.
- R8: If the slave does not acknowledge an address byte or the index byte, `ack_err` is set and the block goes straight to STOP; a NACK on the write data byte does not set it; `ack_err` clears when the next transfer is launched.
- R9: Every bus bit lasts four quarter periods of CLK_HZ/(4·SCL_HZ) clock cycles each, as do START, repeated START and STOP, so a write lasts 116 quarters, a read 156, an address NACK 44, an index NACK 80 and a read-address NACK 120.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command lane write strobe |
| cmd_lane | input | 2 | Lane selected by the write (3 down to 0) |
| cmd_byte | input | 8 | Byte written into the selected lane |
| rd_byte | output | 8 | Byte received by the last read |
| busy | output | 1 | Transfer in progress |
| ack_err | output | 1 | Address or index byte was not acknowledged |
| scl_lo | output | 1 | Pull SCL low when 1, release when 0 |
| sda_lo | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
`busy` rises one clock edge after the lane-0 write and stays high for exactly the quarter count of R9 times the divider, so the bench drives and samples on the falling clock edge and counts the high samples of `busy` against that arithmetic figure. `rd_byte`, `ack_err` and the slave model's memory are settled when `busy` falls and are checked at that moment, never earlier. A bus-level slave model in the bench decodes START, STOP and every ninth clock from the wired lines, so the acknowledge timing is judged at the bus and not inside the design.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_RSTART,
        ST_RECV,
        ST_STOP
    } phase_e;

    typedef enum logic [1:0] {
        BY_ADDR_WR,
        BY_INDEX,
        BY_DATA,
        BY_ADDR_RD
    } byte_e;

    typedef struct packed {
        phase_e     st;
        byte_e      by;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       nak;
        logic       rd;
        logic [6:0] addr;
        logic [7:0] idx;
        logic [7:0] wdat;
        logic [7:0] rdat;
        logic       err;
    } ctl_s;

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int QDIV = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_cmd_lanes.sv
module i2c_cmd_lanes #(
    parameter int LANES = 4,
    parameter int LW    = 8,
    localparam int SELW = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SELW-1:0]           lane,
    input  logic [LW-1:0]             din,
    output logic [(LANES-1)*LW-1:0]   upper
);
    for (genvar g = 1; g < LANES; g++) begin : g_lane
        logic [LW-1:0] val_d, val_q;
        always_comb begin
            val_d = val_q;
            if (we && lane == SELW'(g)) val_d = din;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end
        assign upper[(g-1)*LW +: LW] = val_q;
    end
endmodule

// File: rtl/i2c_line_decode.sv
module i2c_line_decode
    import i2c_cmd_pkg::*;
(
    input  phase_e     st,
    input  logic [1:0] ph,
    input  logic [3:0] bitn,
    input  logic       msb,
    output logic       scl_lo,
    output logic       sda_lo
);
    always_comb begin
        scl_lo = 1'b0;
        sda_lo = 1'b0;
        unique case (st)
            ST_START: begin
                scl_lo = (ph == 2'd3);
                sda_lo = (ph != 2'd0);
            end
            ST_SEND: begin
                scl_lo = (ph == 2'd0) || (ph == 2'd3);
                sda_lo = (bitn != 4'd8) && !msb;
            end
            ST_RECV: begin
                scl_lo = (ph == 2'd0) || (ph == 2'd3);
            end
            ST_RSTART: begin
                scl_lo = (ph == 2'd0) || (ph == 2'd3);
                sda_lo = ph[1];
            end
            ST_STOP: begin
                scl_lo = (ph == 2'd0);
                sda_lo = !ph[1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int CLK_HZ = 25_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [1:0] cmd_lane,
    input  logic [7:0] cmd_byte,
    output logic [7:0] rd_byte,
    output logic       busy,
    output logic       ack_err,
    output logic       scl_lo,
    output logic       sda_lo,
    input  logic       sda_in
);
    localparam int LANES = 4;
    localparam int LW    = 8;
    localparam int QDIV  = CLK_HZ / (4 * SCL_HZ);

    ctl_s q, d;
    logic tick;
    logic [(LANES-1)*LW-1:0] upper;
    logic       cfg_rd;
    logic [6:0] cfg_addr;
    logic [7:0] cfg_idx;
    logic       lane_unused;

    i2c_quarter_tick #(.QDIV(QDIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(q.st != ST_IDLE), .tick(tick)
    );

    i2c_cmd_lanes #(.LANES(LANES), .LW(LW)) lanes_i (
        .clk(clk), .rst_n(rst_n), .we(cmd_we), .lane(cmd_lane),
        .din(cmd_byte), .upper(upper)
    );

    assign cfg_rd      = upper[3*LW-1];
    assign cfg_addr    = upper[LW +: 7];
    assign cfg_idx     = upper[0 +: LW];
    assign lane_unused = ^{upper[2*LW +: LW-1], upper[2*LW-1]};

    i2c_line_decode dec_i (
        .st(q.st), .ph(q.ph), .bitn(q.bitn), .msb(q.sh[7]),
        .scl_lo(scl_lo), .sda_lo(sda_lo)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_we && cmd_lane == 2'd0) begin
                    d.st   = ST_START;
                    d.ph   = 2'd0;
                    d.rd   = cfg_rd;
                    d.addr = cfg_addr;
                    d.idx  = cfg_idx;
                    d.wdat = cmd_byte;
                    d.err  = 1'b0;
                end
            end
            ST_START, ST_RSTART: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) begin
                        d.st   = ST_SEND;
                        d.bitn = 4'd0;
                        d.by   = (q.st == ST_START) ? BY_ADDR_WR : BY_ADDR_RD;
                        d.sh   = {q.addr, q.st == ST_RSTART};
                    end
                end
            end
            ST_SEND: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd2 && q.bitn == 4'd8) d.nak = sda_in;
                    if (q.ph == 2'd3) begin
                        if (q.bitn != 4'd8) begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.bitn = q.bitn + 4'd1;
                        end else begin
                            d.bitn = 4'd0;
                            if (q.nak && q.by != BY_DATA) begin
                                d.err = 1'b1;
                                d.st  = ST_STOP;
                            end else begin
                                unique case (q.by)
                                    BY_ADDR_WR: begin
                                        d.by = BY_INDEX;
                                        d.sh = q.idx;
                                    end
                                    BY_INDEX: begin
                                        if (q.rd) d.st = ST_RSTART;
                                        else begin
                                            d.by = BY_DATA;
                                            d.sh = q.wdat;
                                        end
                                    end
                                    BY_DATA:    d.st = ST_STOP;
                                    BY_ADDR_RD: d.st = ST_RECV;
                                    default: ;
                                endcase
                            end
                        end
                    end
                end
            end
            ST_RECV: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd2 && q.bitn != 4'd8) d.sh = {q.sh[6:0], sda_in};
                    if (q.ph == 2'd3) begin
                        if (q.bitn == 4'd7) d.rdat = q.sh;
                        if (q.bitn == 4'd8) begin
                            d.bitn = 4'd0;
                            d.st   = ST_STOP;
                        end else begin
                            d.bitn = q.bitn + 4'd1;
                        end
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = (q.st != ST_IDLE);
    assign ack_err = q.err;
    assign rd_byte = q.rdat;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [1:0] cmd_lane,
    input logic       busy,
    input logic       ack_err,
    input logic       scl_lo,
    input logic       sda_lo
);
    AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_lane == 2'd0) |=> busy); // R2

    AST_UPPER_LANE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_we && cmd_lane == 2'd0)) |=> !busy); // R1

    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_lo && !sda_lo)); // R7

    AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lo != $past(scl_lo)) |-> (sda_lo == $past(sda_lo))); // R7

    AST_ERR_CLEAR_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ack_err); // R8

    AST_ERR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ack_err)); // R8
endmodule

bind i2c_cmd_master i2c_cmd_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_lane(cmd_lane),
    .busy(busy), .ack_err(ack_err), .scl_lo(scl_lo), .sda_lo(sda_lo)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 800;
    localparam int T_SCL_HZ   = 100;
    localparam int Q          = T_CLK_HZ / (4 * T_SCL_HZ);
    localparam logic [6:0] SLV = 7'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [1:0] cmd_lane = 2'd0;
    logic [7:0] cmd_byte = 8'd0;
    logic [7:0] rd_byte;
    logic       busy, ack_err, scl_lo, sda_lo;
    logic       slv_pull = 1'b0;
    wire        scl_w = !scl_lo;
    wire        sda_w = !(sda_lo || slv_pull);

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_master #(.CLK_HZ(T_CLK_HZ), .SCL_HZ(T_SCL_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_lane(cmd_lane),
        .cmd_byte(cmd_byte), .rd_byte(rd_byte), .busy(busy), .ack_err(ack_err),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_w)
    );

    // ---------------- bus slave model ----------------
    logic [7:0] mem [0:255];
    logic [7:0] shreg = 8'd0;
    logic [7:0] sidx = 8'd0;
    int  bitn = 0;
    bit  ps = 1'b1, pd = 1'b1;
    bit  in_x = 0, first = 0, active = 0, sending = 0, tx_on = 0, want_idx = 0;
    bit  nak_idx = 0, nak_rd = 0, nak_dat = 0;
    int  n_start = 0, n_stop = 0;

    always @(scl_w or sda_w) begin
        if (scl_w && ps && pd && !sda_w) begin
            n_start++; in_x = 1; bitn = 0; first = 1; sending = 0; tx_on = 0; slv_pull = 0;
        end else if (scl_w && ps && !pd && sda_w) begin
            n_stop++; in_x = 0; sending = 0; tx_on = 0; slv_pull = 0;
        end else if (scl_w && !ps) begin
            if (in_x) begin
                if (bitn < 8) shreg = {shreg[6:0], sda_w};
                bitn++;
            end
        end else if (!scl_w && ps && in_x) begin
            if (bitn == 8) begin
                if (first) begin
                    first    = 0;
                    active   = (shreg[7:1] == SLV) && !(shreg[0] && nak_rd);
                    sending  = active && shreg[0];
                    want_idx = !shreg[0];
                    slv_pull = active;
                end else if (sending) begin
                    slv_pull = 0;
                end else if (active) begin
                    if (want_idx) begin
                        sidx = shreg; want_idx = 0; slv_pull = !nak_idx;
                    end else begin
                        mem[sidx] = shreg; slv_pull = !nak_dat;
                    end
                end
            end else if (bitn >= 9) begin
                bitn = 0;
                slv_pull = 0;
                if (sending && !tx_on) begin
                    tx_on = 1; slv_pull = !mem[sidx][7];
                end else if (tx_on) begin
                    tx_on = 0; sending = 0;
                end
            end else if (tx_on) begin
                slv_pull = !mem[sidx][7 - bitn];
            end
        end
        ps = scl_w;
        pd = sda_w;
    end

    // same-cycle SCL/SDA movement monitor
    int  joint_moves = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (scl_lo != prev_scl) && (sda_lo != prev_sda)) joint_moves++;
        prev_scl <= scl_lo;
        prev_sda <= sda_lo;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] lane, input logic [7:0] val);
        @(negedge clk);
        cmd_we = 1'b1; cmd_lane = lane; cmd_byte = val;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // counts busy-high samples; optionally fires a lane-0 write mid-transfer
    task automatic wait_done(input bit inject, input logic [7:0] inj_val, output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (inject && cyc == 20) begin
                cmd_we = 1'b1; cmd_lane = 2'd0; cmd_byte = inj_val;
            end else begin
                cmd_we = 1'b0;
            end
            @(negedge clk);
        end
        cmd_we = 1'b0;
    endtask

    task automatic txn(input bit rd, input logic [6:0] a, input logic [7:0] ix,
                       input logic [7:0] dat, output int cyc);
        put(2'd3, rd ? 8'h80 : 8'h00);
        put(2'd2, {1'b0, a});
        put(2'd1, ix);
        n_start = 0; n_stop = 0;
        put(2'd0, dat);
        wait_done(1'b0, 8'd0, cyc);
    endtask

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    logic [7:0] expm [0:255];

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = init_val(i);
            expm[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(!busy && !ack_err, "R2 reset idle/no error", {busy, ack_err}, 0);
        chk(!scl_lo && !sda_lo, "R7 reset lines released", {scl_lo, sda_lo}, 0);

        // R1: upper lanes alone start nothing
        put(2'd3, 8'h80); put(2'd2, {1'b0, SLV}); put(2'd1, 8'h44);
        begin
            int seen = 0;
            for (int k = 0; k < 12; k++) begin
                if (busy || scl_lo || sda_lo) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R1 upper lanes start nothing", seen, 0);
        end

        // R5/R4/R9: write sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ix, dt;
            ix = 8'((i * 29 + 3) & 8'hFF);
            dt = 8'((i * 53 + 7) & 8'hFF);
            txn(1'b0, SLV, ix, dt, cyc);
            expm[ix] = dt;
            chk(cyc == 116 * Q, "R9 write duration", cyc, 116 * Q);
            chk(mem[ix] == dt, "R5 write data at slave", mem[ix], dt);
            chk(!ack_err, "R5 write acked", ack_err, 0);
            chk(n_start == 1 && n_stop == 1, "R5 one START one STOP", n_start * 10 + n_stop, 11);
        end

        // R6/R4: read sweep over written and untouched indices
        for (int i = 0; i < 12; i++) begin
            logic [7:0] ix;
            ix = (i < 8) ? 8'((i * 29 + 3) & 8'hFF) : 8'(8'hF0 + i);
            txn(1'b1, SLV, ix, 8'h00, cyc);
            chk(rd_byte == expm[ix], "R6 read data", rd_byte, expm[ix]);
            chk(cyc == 156 * Q, "R9 read duration", cyc, 156 * Q);
            chk(n_start == 2 && n_stop == 1, "R6 repeated START", n_start * 10 + n_stop, 21);
            chk(!ack_err, "R6 read acked", ack_err, 0);
        end

        // R1: lane order does not matter
        put(2'd1, 8'h9C); put(2'd3, 8'h00); put(2'd2, {1'b0, SLV});
        put(2'd0, 8'hC3);
        wait_done(1'b0, 8'd0, cyc);
        chk(mem[8'h9C] == 8'hC3, "R1 lanes in any order", mem[8'h9C], 8'hC3);

        // R3: lane-0 write while busy ignored
        put(2'd3, 8'h00); put(2'd2, {1'b0, SLV}); put(2'd1, 8'h21);
        put(2'd0, 8'h66);
        wait_done(1'b1, 8'h99, cyc);
        chk(mem[8'h21] == 8'h66, "R3 busy write ignored (data)", mem[8'h21], 8'h66);
        chk(cyc == 116 * Q, "R3 busy write ignored (length)", cyc, 116 * Q);
        repeat (4) @(negedge clk);
        chk(!busy, "R3 no relaunch after ignored write", busy, 0);

        // R8: address NACK on write and read
        txn(1'b0, 7'h13, 8'h05, 8'hAA, cyc);
        chk(ack_err, "R8 address NACK flagged", ack_err, 1);
        chk(cyc == 44 * Q, "R8 address NACK stops", cyc, 44 * Q);
        chk(mem[8'h05] == expm[8'h05], "R8 no write after NACK", mem[8'h05], expm[8'h05]);
        txn(1'b1, 7'h13, 8'h05, 8'h00, cyc);
        chk(ack_err && cyc == 44 * Q, "R8 read address NACK", cyc, 44 * Q);

        // R8: flag clears on next good launch
        txn(1'b0, SLV, 8'h30, 8'h5A, cyc);
        chk(!ack_err, "R8 error cleared by launch", ack_err, 0);

        // R8: index NACK
        nak_idx = 1;
        txn(1'b0, SLV, 8'h31, 8'h11, cyc);
        nak_idx = 0;
        chk(ack_err, "R8 index NACK flagged", ack_err, 1);
        chk(cyc == 80 * Q, "R8 index NACK stops", cyc, 80 * Q);

        // R8: read-address NACK after repeated START
        nak_rd = 1;
        txn(1'b1, SLV, 8'h31, 8'h00, cyc);
        nak_rd = 0;
        chk(ack_err && cyc == 120 * Q, "R8 read-phase address NACK", cyc, 120 * Q);

        // R8: data NACK not flagged
        nak_dat = 1;
        txn(1'b0, SLV, 8'h32, 8'h77, cyc);
        nak_dat = 0;
        chk(!ack_err, "R8 data NACK not flagged", ack_err, 0);
        chk(cyc == 116 * Q, "R8 data NACK full length", cyc, 116 * Q);

        // R7: bus released at the end and never moved jointly
        chk(!scl_lo && !sda_lo, "R7 idle lines released", {scl_lo, sda_lo}, 0);
        chk(joint_moves == 0, "R7 SCL and SDA never move together", joint_moves, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule